// File: doc/BRIEF.md
# Embedded Controller Frame Classifier

This block inspects the first four header bytes of a frame that an embedded controller has sent to the host and turns them into the handful of facts the receive path needs: whether the frame is an unsolicited event or the answer to a request, how many bytes the whole frame should contain, which notification type it carries, whether the controller rejected the request, and whether the frame closes the synchronous request that is currently outstanding.

The receive logic presents the header bytes together with a flag that says whether any byte has arrived yet, then pulses `frame_valid`. One clock later the classification appears on the outputs with a one-cycle `res_valid` pulse. The outputs then stay frozen until the next strobe, so downstream logic may sample them at leisure. The block stores no frame data and does not track the transfer on the wire.

Top module: `ec_frame_classifier`

## Requirements
- R1: `is_event` equals bit 7 of `hdr0`; a set bit marks an unsolicited event and a clear bit marks a response.
- R2: For an event, `hdr0[6:5]` selects the length class: 2'b00 gives `frame_len` 2 and 2'b01 gives `frame_len` 3. These fixed lengths do not depend on `any_rx`.
- R3: A response, or an event with `hdr0[6:5]` = 2'b10 (variable class), gives `frame_len` = `hdr1` + 2 when `any_rx` is 1. It gives 0 when `any_rx` is 0.
- R4: An event with `hdr0[6:5]` = 2'b11 gives `frame_len` 0 and sets `len_bad`. `len_bad` is 0 in every other case.
- R5: `resp_err` is 1 exactly when the frame is a response and `hdr3` is nonzero. `note_fwd` is 1 only when neither `resp_err` nor `tag_hit` is set.
- R6: `note_type` equals `hdr0` AND 8'h8F.
- R7: `sys_event` is 1 exactly when the frame is an event and `hdr0[3:0]` equals 4'h5.
- R8: `tag_hit` is 1 exactly when `pend_valid` is 1 and {`hdr2`, `hdr0`} equals `pend_tag`, with `hdr2` in the upper byte.
- R9: The results of a `frame_valid` strobe appear on the cycle after the strobe, together with a one-cycle `res_valid` pulse. Every result output then holds its value while `frame_valid` stays low, whatever the inputs do.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Strobe: classify the presented header |
| any_rx | input | 1 | At least one byte of the frame has arrived |
| hdr0 | input | 8 | Header byte 0 (kind, length class, type) |
| hdr1 | input | 8 | Header byte 1 (payload count) |
| hdr2 | input | 8 | Header byte 2 (upper half of the pairing tag) |
| hdr3 | input | 8 | Header byte 3 (response status) |
| pend_valid | input | 1 | A synchronous request is outstanding |
| pend_tag | input | 16 | Tag of that request, {request byte1, request byte0} |
| res_valid | output | 1 | One-cycle pulse: new results present |
| is_event | output | 1 | Frame is an unsolicited event |
| frame_len | output | 9 | Expected total frame length in bytes |
| len_bad | output | 1 | Length class is undefined |
| note_type | output | 8 | Notification type code |
| note_fwd | output | 1 | Frame should be forwarded as a notification |
| resp_err | output | 1 | Response reports a controller error |
| sys_event | output | 1 | Frame is a system event |
| tag_hit | output | 1 | Frame completes the pending request |

## Verification
Every result is due one clock edge after the edge that samples `frame_valid`. The bench raises the strobe on a falling edge, drops it on the next falling edge, and compares all fields at that falling edge, half a period after the register update. It then changes every input with the strobe low, waits one more full cycle, and checks that the outputs are unchanged and that `res_valid` has fallen. This makes the hold behaviour visible at the ports.

// File: rtl/ec_frame_pkg.sv
package ec_frame_pkg;
   typedef enum logic [1:0] {
      LCLS_FIX2 = 2'b00,
      LCLS_FIX3 = 2'b01,
      LCLS_VAR  = 2'b10,
      LCLS_RSVD = 2'b11
   } len_class_e;

   localparam int unsigned KIND_BIT   = 7;
   localparam int unsigned CLS_LSB    = 5;
   localparam logic [7:0]  TYPE_MASK  = 8'h8F;
   localparam logic [3:0]  SYS_NIBBLE = 4'h5;
   localparam int unsigned FIX2_LEN   = 2;
   localparam int unsigned FIX3_LEN   = 3;
   localparam int unsigned HDR_EXTRA  = 2;
endpackage

// File: rtl/ec_len_decode.sv
module ec_len_decode
   import ec_frame_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned LEN_W = BYTE_W + 1
) (
   input  logic [BYTE_W-1:0] hdr0,
   input  logic [BYTE_W-1:0] hdr1,
   input  logic              any_rx,
   output logic [LEN_W-1:0]  len,
   output logic              bad
);
   len_class_e cls;
   logic       ev;
   logic [LEN_W-1:0] var_len;

   assign ev  = hdr0[KIND_BIT];
   assign cls = len_class_e'(hdr0[CLS_LSB +: 2]);
   assign var_len = any_rx ? ({1'b0, hdr1} + LEN_W'(HDR_EXTRA)) : '0;

   always_comb begin
      len = var_len;
      bad = 1'b0;
      if (ev) begin
         unique case (cls)
            LCLS_FIX2: len = LEN_W'(FIX2_LEN);
            LCLS_FIX3: len = LEN_W'(FIX3_LEN);
            LCLS_VAR:  len = var_len;
            default: begin
               len = '0;
               bad = 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/ec_kind_decode.sv
module ec_kind_decode
   import ec_frame_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] hdr0,
   input  logic [BYTE_W-1:0] hdr3,
   output logic              ev,
   output logic [BYTE_W-1:0] ntype,
   output logic              rerr,
   output logic              sysev
);
   assign ev    = hdr0[KIND_BIT];
   assign ntype = hdr0 & BYTE_W'(TYPE_MASK);
   assign rerr  = !hdr0[KIND_BIT] && (hdr3 != '0);
   assign sysev = hdr0[KIND_BIT] && (hdr0[3:0] == SYS_NIBBLE);
endmodule

// File: rtl/ec_tag_match.sv
module ec_tag_match #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned TAG_W = 2 * BYTE_W
) (
   input  logic [BYTE_W-1:0] hdr0,
   input  logic [BYTE_W-1:0] hdr2,
   input  logic              pend_valid,
   input  logic [TAG_W-1:0]  pend_tag,
   output logic              hit
);
   logic [TAG_W-1:0] frame_tag;
   assign frame_tag = {hdr2, hdr0};
   assign hit = pend_valid && (frame_tag == pend_tag);
endmodule

// File: rtl/ec_frame_classifier.sv
module ec_frame_classifier #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned LEN_W = BYTE_W + 1,
   localparam int unsigned TAG_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid,
   input  logic              any_rx,
   input  logic [BYTE_W-1:0] hdr0,
   input  logic [BYTE_W-1:0] hdr1,
   input  logic [BYTE_W-1:0] hdr2,
   input  logic [BYTE_W-1:0] hdr3,
   input  logic              pend_valid,
   input  logic [TAG_W-1:0]  pend_tag,
   output logic              res_valid,
   output logic              is_event,
   output logic [LEN_W-1:0]  frame_len,
   output logic              len_bad,
   output logic [BYTE_W-1:0] note_type,
   output logic              note_fwd,
   output logic              resp_err,
   output logic              sys_event,
   output logic              tag_hit
);
   if (BYTE_W != 8) begin : g_bad_width
      $error("ec_frame_classifier: header field positions need BYTE_W of 8");
   end

   logic              c_ev, c_bad, c_rerr, c_sys, c_hit;
   logic [LEN_W-1:0]  c_len;
   logic [BYTE_W-1:0] c_type;

   ec_len_decode #(.BYTE_W(BYTE_W)) u_len (
      .hdr0(hdr0), .hdr1(hdr1), .any_rx(any_rx), .len(c_len), .bad(c_bad)
   );

   ec_kind_decode #(.BYTE_W(BYTE_W)) u_kind (
      .hdr0(hdr0), .hdr3(hdr3), .ev(c_ev), .ntype(c_type),
      .rerr(c_rerr), .sysev(c_sys)
   );

   ec_tag_match #(.BYTE_W(BYTE_W)) u_tag (
      .hdr0(hdr0), .hdr2(hdr2), .pend_valid(pend_valid),
      .pend_tag(pend_tag), .hit(c_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         is_event  <= 1'b0;
         frame_len <= '0;
         len_bad   <= 1'b0;
         note_type <= '0;
         note_fwd  <= 1'b0;
         resp_err  <= 1'b0;
         sys_event <= 1'b0;
         tag_hit   <= 1'b0;
      end else begin
         res_valid <= frame_valid;
         if (frame_valid) begin
            is_event  <= c_ev;
            frame_len <= c_len;
            len_bad   <= c_bad;
            note_type <= c_type;
            note_fwd  <= !c_rerr && !c_hit;
            resp_err  <= c_rerr;
            sys_event <= c_sys;
            tag_hit   <= c_hit;
         end
      end
   end

   // R9: a pulse follows each strobe; results freeze without one
   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> res_valid);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |=> $stable({is_event, frame_len, len_bad, note_type,
                                note_fwd, resp_err, sys_event, tag_hit}));
   // R4: an undefined class carries no length
   a_r4_bad_len_zero: assert property (@(posedge clk) disable iff (!rst_n)
      len_bad |-> (frame_len == '0) && is_event);
   // R5: an error response is never an event and never forwarded
   a_r5_err_resp: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> !is_event && !note_fwd);
   // R7: system events are events
   a_r7_sys_is_event: assert property (@(posedge clk) disable iff (!rst_n)
      sys_event |-> is_event);
   // R5: a matched frame is not forwarded
   a_r5_hit_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      tag_hit |-> !note_fwd);
endmodule

// File: tb/ec_frame_classifier_bench.sv
module ec_frame_classifier_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_valid = 1'b0;
   logic        any_rx = 1'b0;
   logic [7:0]  hdr0 = '0, hdr1 = '0, hdr2 = '0, hdr3 = '0;
   logic        pend_valid = 1'b0;
   logic [15:0] pend_tag = '0;
   logic        res_valid, is_event, len_bad, note_fwd, resp_err, sys_event, tag_hit;
   logic [8:0]  frame_len;
   logic [7:0]  note_type;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ec_frame_classifier u_ec_frame_classifier (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .any_rx(any_rx),
      .hdr0(hdr0), .hdr1(hdr1), .hdr2(hdr2), .hdr3(hdr3),
      .pend_valid(pend_valid), .pend_tag(pend_tag),
      .res_valid(res_valid), .is_event(is_event), .frame_len(frame_len),
      .len_bad(len_bad), .note_type(note_type), .note_fwd(note_fwd),
      .resp_err(resp_err), .sys_event(sys_event), .tag_hit(tag_hit)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_len(input logic [7:0] h0, input logic [7:0] h1, input logic a);
      int v;
      v = a ? int'(h1) + 2 : 0;
      if (!h0[7]) return v;
      case (h0[6:5])
         2'b00:   return 2;
         2'b01:   return 3;
         2'b10:   return v;
         default: return 0;
      endcase
   endfunction

   task automatic apply(input logic [7:0] h0, h1, h2, h3, input logic a,
                        input logic pv, input logic [15:0] pt);
      int e_ev, e_err, e_hit;
      @(negedge clk);
      hdr0 = h0; hdr1 = h1; hdr2 = h2; hdr3 = h3;
      any_rx = a; pend_valid = pv; pend_tag = pt;
      frame_valid = 1'b1;
      @(negedge clk);
      frame_valid = 1'b0;
      e_ev  = int'(h0[7]);
      e_err = int'(!h0[7] && h3 != 8'h00);
      e_hit = int'(pv && ({h2, h0} == pt));
      chk("R9 res_valid pulse", int'(res_valid), 1);
      chk("R1 is_event", int'(is_event), e_ev);
      chk("R2/R3 frame_len", int'(frame_len), exp_len(h0, h1, a));
      chk("R4 len_bad", int'(len_bad), int'(h0[7] && h0[6:5] == 2'b11));
      chk("R6 note_type", int'(note_type), int'(h0 & 8'h8F));
      chk("R5 resp_err", int'(resp_err), e_err);
      chk("R5 note_fwd", int'(note_fwd), int'(e_err == 0 && e_hit == 0));
      chk("R7 sys_event", int'(sys_event), int'(h0[7] && h0[3:0] == 4'h5));
      chk("R8 tag_hit", int'(tag_hit), e_hit);
      // R9 hold: disturb every input without a strobe
      hdr0 = ~h0; hdr1 = ~h1; hdr2 = ~h2; hdr3 = ~h3;
      any_rx = ~a; pend_valid = 1'b1; pend_tag = {~h2, ~h0};
      @(negedge clk);
      chk("R9 res_valid falls", int'(res_valid), 0);
      chk("R9 hold frame_len", int'(frame_len), exp_len(h0, h1, a));
      chk("R9 hold tag_hit", int'(tag_hit), e_hit);
      chk("R9 hold is_event", int'(is_event), e_ev);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 res_valid", int'(res_valid), 0);
      chk("R10 frame_len", int'(frame_len), 0);
      chk("R10 flags", int'({is_event, len_bad, note_fwd, resp_err, sys_event, tag_hit}), 0);
      chk("R10 note_type", int'(note_type), 0);
      rst_n = 1'b1;
      // directed corners
      apply(8'h80, 8'h33, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0);   // R2 fix2 without any_rx
      apply(8'hA5, 8'h33, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0);   // R2 fix3, R7 system event
      apply(8'hC3, 8'h10, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0);   // R3 variable event
      apply(8'hC3, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0);   // R3 nothing received
      apply(8'hE5, 8'h10, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0);   // R4 reserved class
      apply(8'h01, 8'hFF, 8'h15, 8'h00, 1'b1, 1'b0, 16'h0);   // R3 max length 257
      apply(8'h05, 8'h04, 8'h15, 8'h02, 1'b1, 1'b0, 16'h0);   // R5 error response, R7 not event
      apply(8'h0A, 8'h04, 8'h15, 8'h00, 1'b1, 1'b1, 16'h150A); // R8 hit
      apply(8'h0A, 8'h04, 8'h15, 8'h00, 1'b1, 1'b0, 16'h150A); // R8 no pending
      apply(8'h0A, 8'h04, 8'h15, 8'h00, 1'b1, 1'b1, 16'h0A15); // R8 swapped bytes miss
      apply(8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b1, 16'hFFFF); // R6 mask, R4
      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [7:0] r0, r1, r2, r3;
         logic       pv, hit_try;
         logic [15:0] pt;
         r0 = 8'($urandom);
         r1 = 8'($urandom);
         r2 = 8'($urandom);
         r3 = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
         pv = 1'($urandom);
         hit_try = ($urandom % 2) == 0;
         pt = hit_try ? {r2, r0} : 16'($urandom);
         apply(r0, r1, r2, r3, 1'($urandom % 4 != 0), pv, pt);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule